// File: doc/BRIEF.md
# Half-Step Peripheral Rate Divider

This block produces a clock-enable for one peripheral from one of several reference clock-enable inputs. A source code picks which reference enable feeds the divider. The divider then emits single-cycle output enables. In fractional mode their long-run rate is the reference rate times 2/(d+2), where d is an 8-bit divisor in 7.1 fixed point: the upper seven bits hold the integer part minus one, and bit 0 adds one half. In integer mode, which is meant for serial-bus clocks, a 16-bit field n divides the rate by n+1.

A configuration write presents the source code, the mode and the divisor together. The block checks the divisor against the field width of the requested mode. A divisor that does not fit is refused: the running configuration stays in force and an error flag is raised. A valid write replaces the whole configuration and restarts the divider phase from zero. A source code with no reference behind it silences the output and also raises the error flag.

Top module: `periph_rate_div`

## Requirements
- R1: In fractional mode (cfg_int_i=0) the output gives exactly floor(2·N/(d+2)) enables for N selected reference enables counted from a valid write. So d=0 divides by 1, d=1 by 1.5 and d=255 by 128.5.
- R2: With odd d in fractional mode the spacing between output enables alternates between two lengths. With d=1 and an enable every cycle, the output pattern after a write is 0,1,1 repeating. With d=3 the pattern is 0,0,1,0,1 repeating.
- R3: In integer mode (cfg_int_i=1) the output gives floor(N/(n+1)) enables for N selected reference enables, where n is the 16-bit divisor. A value of n up to 65535 is accepted even when it exceeds 8 bits.
- R4: Source codes 0 to 6 select ref_ce_i[code]. Enables on the non-selected inputs have no effect on the output.
- R5: Source code 7 is unused. While it is in force, clk_en_o stays 0 and cfg_err_o is 1.
- R6: A write whose divisor has a bit set above bit 7 (fractional mode) or above bit 15 (integer mode) is refused. cfg_err_o goes to 1 and the previous configuration and phase keep running. The next valid write clears the flag.
- R7: A valid write clears the divider phase. The first output enable then comes on the ceil((d+2)/2)-th selected enable in fractional mode, or the (n+1)-th in integer mode.
- R8: After reset, clk_en_o and cfg_err_o are 0, and the block runs source 0 in fractional mode with d=0.
- R9: clk_en_o is registered. It is high for one cycle, in the cycle after the selected reference enable that completes a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_ce_i | input | NUM_SRC | Reference clock-enables, one per source code |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_src_i | input | SRC_W | Source code to apply |
| cfg_int_i | input | 1 | 1 selects integer mode, 0 selects fractional mode |
| cfg_div_i | input | IN_W | Divisor to apply |
| clk_en_o | output | 1 | Divided output clock-enable |
| cfg_err_o | output | 1 | Refused divisor or unused source code |

## Verification
Every fractional divisor from 0 to 255 is run over a long stretch of back-to-back reference enables, and the pulse count is compared with 2·N/(d+2). This separates a correct half-step from a divider that rounds or drops the half bit. A table then mixes sources, modes and integer divisors, which tells a mis-wired selector apart from a wrong ratio. Exact pulse patterns for odd divisors, a write in the middle of a period and a sparse enable stream show whether the phase is kept correctly, restarts on a write and reaches the output with one register of delay. Oversized divisors in each mode, and an all-inputs stimulus with the unused code, check that bad configurations are refused or silenced.

// File: rtl/periph_rate_div_pkg.sv
package periph_rate_div_pkg;

  typedef enum logic {
    DIV_FRAC = 1'b0,
    DIV_INT  = 1'b1
  } div_mode_e;

endpackage

// File: rtl/prd_cfg.sv
module prd_cfg
  import periph_rate_div_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int SRC_W   = 3,
  parameter int FRAC_W  = 8,
  parameter int INT_W   = 16,
  parameter int IN_W    = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [SRC_W-1:0] src_i,
  input  div_mode_e        mode_i,
  input  logic [IN_W-1:0]  div_i,
  output logic [SRC_W-1:0] src_q,
  output div_mode_e        mode_q,
  output logic [INT_W-1:0] div_q,
  output logic             apply_o,
  output logic             unused_o,
  output logic             err_o
);

  logic ovf;
  logic ovf_q;

  always_comb begin
    if (mode_i == DIV_INT) ovf = |div_i[IN_W-1:INT_W];
    else                   ovf = |div_i[IN_W-1:FRAC_W];
  end

  assign apply_o = we_i && !ovf;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      mode_q <= DIV_FRAC;
      div_q  <= '0;
      ovf_q  <= 1'b0;
    end else if (we_i) begin
      ovf_q <= ovf;
      if (!ovf) begin
        src_q  <= src_i;
        mode_q <= mode_i;
        div_q  <= div_i[INT_W-1:0];
      end
    end
  end

  assign unused_o = (src_q >= SRC_W'(NUM_SRC));
  assign err_o    = ovf_q || unused_o;

  AST_OVF_KEEPS_CFG: assert property (@(posedge clk) disable iff (rst)
    (we_i && ovf) |=> ($stable(div_q) && $stable(src_q) && err_o)); // R6

  AST_FRAC_FIELD_FITS: assert property (@(posedge clk) disable iff (rst)
    (mode_q == DIV_FRAC) |-> (div_q < INT_W'(1 << FRAC_W))); // R6

endmodule

// File: rtl/prd_srcsel.sv
module prd_srcsel #(
  parameter int NUM_SRC = 7,
  parameter int SRC_W   = 3
) (
  input  logic [NUM_SRC-1:0] ref_ce_i,
  input  logic [SRC_W-1:0]   src_i,
  output logic               ce_o
);

  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = ref_ce_i[g] && (src_i == SRC_W'(g));
  end

  assign ce_o = |hit;

endmodule

// File: rtl/prd_accum.sv
module prd_accum
  import periph_rate_div_pkg::*;
#(
  parameter int INT_W = 16,
  parameter int ACC_W = INT_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             ce_i,
  input  div_mode_e        mode_i,
  input  logic [INT_W-1:0] div_i,
  output logic             pulse_o
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] limit;
  logic [ACC_W-1:0] acc_next;

  always_comb begin
    step     = (mode_i == DIV_INT) ? ACC_W'(1) : ACC_W'(2);
    limit    = ACC_W'(div_i) + step;
    acc_next = acc_q + step;
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      acc_q   <= '0;
      pulse_o <= 1'b0;
    end else if (ce_i) begin
      if (acc_next >= limit) begin
        acc_q   <= acc_next - limit;
        pulse_o <= 1'b1;
      end else begin
        acc_q   <= acc_next;
        pulse_o <= 1'b0;
      end
    end else begin
      pulse_o <= 1'b0;
    end
  end

  AST_ACC_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (acc_q < limit)); // R1

  AST_CLEAR_SILENCES: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> !pulse_o); // R7

  AST_PULSE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> $past(ce_i)); // R9

endmodule

// File: rtl/periph_rate_div.sv
module periph_rate_div
  import periph_rate_div_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int SRC_W   = 3,
  parameter int FRAC_W  = 8,
  parameter int INT_W   = 16,
  parameter int IN_W    = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] ref_ce_i,
  input  logic               cfg_we_i,
  input  logic [SRC_W-1:0]   cfg_src_i,
  input  logic               cfg_int_i,
  input  logic [IN_W-1:0]    cfg_div_i,
  output logic               clk_en_o,
  output logic               cfg_err_o
);

  localparam int ACC_W = INT_W + 2;

  logic [SRC_W-1:0] src_q;
  div_mode_e        mode_q;
  logic [INT_W-1:0] div_q;
  logic             apply;
  logic             unused;
  logic             sel_ce;
  div_mode_e        mode_in;

  assign mode_in = cfg_int_i ? DIV_INT : DIV_FRAC;

  prd_cfg #(
    .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .FRAC_W(FRAC_W),
    .INT_W(INT_W), .IN_W(IN_W)
  ) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .we_i    (cfg_we_i),
    .src_i   (cfg_src_i),
    .mode_i  (mode_in),
    .div_i   (cfg_div_i),
    .src_q   (src_q),
    .mode_q  (mode_q),
    .div_q   (div_q),
    .apply_o (apply),
    .unused_o(unused),
    .err_o   (cfg_err_o)
  );

  prd_srcsel #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_sel (
    .ref_ce_i(ref_ce_i),
    .src_i   (src_q),
    .ce_o    (sel_ce)
  );

  prd_accum #(.INT_W(INT_W), .ACC_W(ACC_W)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .clear_i(apply),
    .ce_i   (sel_ce && !unused),
    .mode_i (mode_q),
    .div_i  (div_q),
    .pulse_o(clk_en_o)
  );

  AST_UNUSED_SRC_SILENT: assert property (@(posedge clk) disable iff (rst)
    unused |-> (!clk_en_o && cfg_err_o)); // R5

endmodule

// File: tb/periph_rate_div_tb.sv
module periph_rate_div_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_SRC    = 7;
  localparam int IN_W       = 20;
  localparam int NVEC       = 12;

  // {int_mode, src, divisor, n_ce, expected_pulses}
  localparam logic [47:0] VEC [NVEC] = '{
    {1'b0, 3'd0, 20'd0,   12'd120, 12'd120},
    {1'b0, 3'd1, 20'd1,   12'd120, 12'd80},
    {1'b0, 3'd2, 20'd2,   12'd120, 12'd60},
    {1'b0, 3'd3, 20'd3,   12'd120, 12'd48},
    {1'b0, 3'd4, 20'd6,   12'd120, 12'd30},
    {1'b0, 3'd5, 20'd13,  12'd120, 12'd16},
    {1'b0, 3'd6, 20'd38,  12'd120, 12'd6},
    {1'b0, 3'd0, 20'd255, 12'd514, 12'd4},
    {1'b1, 3'd0, 20'd0,   12'd120, 12'd120},
    {1'b1, 3'd2, 20'd4,   12'd120, 12'd24},
    {1'b1, 3'd6, 20'd59,  12'd120, 12'd2},
    {1'b1, 3'd3, 20'd7,   12'd120, 12'd15}
  };

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NUM_SRC-1:0] ref_ce_i = '0;
  logic               cfg_we_i = 1'b0;
  logic [2:0]         cfg_src_i = '0;
  logic               cfg_int_i = 1'b0;
  logic [IN_W-1:0]    cfg_div_i = '0;
  logic               clk_en_o;
  logic               cfg_err_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periph_rate_div u_dut (
    .clk      (clk),
    .rst      (rst),
    .ref_ce_i (ref_ce_i),
    .cfg_we_i (cfg_we_i),
    .cfg_src_i(cfg_src_i),
    .cfg_int_i(cfg_int_i),
    .cfg_div_i(cfg_div_i),
    .clk_en_o (clk_en_o),
    .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic im, input logic [2:0] src, input logic [IN_W-1:0] dv);
    cfg_we_i  = 1'b1;
    cfg_int_i = im;
    cfg_src_i = src;
    cfg_div_i = dv;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic run_count(input logic [NUM_SRC-1:0] mask, input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      ref_ce_i = mask;
      @(negedge clk);
      cnt += int'(clk_en_o);
    end
    ref_ce_i = '0;
  endtask

  task automatic run_pattern(input logic [NUM_SRC-1:0] mask, input int n, output logic [15:0] pat);
    pat = '0;
    for (int i = 0; i < n; i++) begin
      ref_ce_i = mask;
      @(negedge clk);
      pat = {pat[14:0], clk_en_o};
    end
    ref_ce_i = '0;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int          cnt;
    logic [15:0] pat;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R8 reset state
    chk("R8 clk_en after reset", int'(clk_en_o), 0);
    chk("R8 err after reset", int'(cfg_err_o), 0);
    run_count(7'b0000001, 10, cnt);
    chk("R8 default src0 divide-by-1", cnt, 10);

    // R1 R3 R4 table of mixed sources and modes
    for (int i = 0; i < NVEC; i++) begin
      logic [47:0] v;
      v = VEC[i];
      do_write(v[47], v[46:44], v[43:24]);
      run_count(NUM_SRC'(1) << v[46:44], int'(v[23:12]), cnt);
      chk(v[47] ? "R3 integer table" : "R1 fractional table", cnt, int'(v[11:0]));
    end

    // R1 sweep over every fractional divisor
    for (int d = 0; d < 256; d++) begin
      do_write(1'b0, 3'd0, IN_W'(d));
      run_count(7'b0000001, 300, cnt);
      chk("R1 sweep", cnt, 600 / (d + 2));
    end

    // R3 integer divisor above 8 bits is accepted
    do_write(1'b1, 3'd1, 20'd300);
    chk("R3 wide integer no error", int'(cfg_err_o), 0);
    run_count(7'b0000010, 602, cnt);
    chk("R3 wide integer count", cnt, 2);

    // R4 non-selected inputs ignored
    do_write(1'b0, 3'd4, 20'd0);
    run_count(7'b1101111, 40, cnt);
    chk("R4 other sources ignored", cnt, 0);
    run_count(7'b0010000, 5, cnt);
    chk("R4 selected source 4", cnt, 5);

    // R2 alternating intervals
    do_write(1'b0, 3'd0, 20'd1);
    run_pattern(7'b0000001, 9, pat);
    chk("R2 d=1 pattern", int'(pat[8:0]), int'(9'b011011011));
    do_write(1'b0, 3'd0, 20'd3);
    run_pattern(7'b0000001, 10, pat);
    chk("R2 d=3 pattern", int'(pat[9:0]), int'(10'b0010100101));

    // R7 write restarts the phase
    do_write(1'b0, 3'd0, 20'd6);
    run_count(7'b0000001, 3, cnt);
    chk("R7 no pulse before period", cnt, 0);
    do_write(1'b0, 3'd0, 20'd6);
    run_pattern(7'b0000001, 4, pat);
    chk("R7 full period after rewrite", int'(pat[3:0]), int'(4'b0001));
    do_write(1'b1, 3'd0, 20'd2);
    run_pattern(7'b0000001, 3, pat);
    chk("R7 integer first pulse", int'(pat[2:0]), int'(3'b001));

    // R9 one-cycle registered pulse
    do_write(1'b0, 3'd0, 20'd0);
    ref_ce_i = 7'b0000001;
    #1;
    chk("R9 not combinational", int'(clk_en_o), 0);
    @(negedge clk);
    ref_ce_i = '0;
    chk("R9 pulse after enable", int'(clk_en_o), 1);
    @(negedge clk);
    chk("R9 single cycle", int'(clk_en_o), 0);

    // R5 unused source code
    do_write(1'b0, 3'd7, 20'd0);
    chk("R5 error flag", int'(cfg_err_o), 1);
    run_count(7'b1111111, 20, cnt);
    chk("R5 output gated", cnt, 0);
    do_write(1'b0, 3'd0, 20'd0);
    chk("R5 error clears", int'(cfg_err_o), 0);

    // R6 overflow refused, previous config and phase kept
    do_write(1'b0, 3'd0, 20'd6);
    do_write(1'b0, 3'd0, 20'd256);
    chk("R6 frac overflow flag", int'(cfg_err_o), 1);
    run_count(7'b0000001, 80, cnt);
    chk("R6 old frac config kept", cnt, 20);
    do_write(1'b1, 3'd0, 20'd300);
    chk("R6 flag cleared", int'(cfg_err_o), 0);
    run_count(7'b0000001, 600, cnt);
    chk("R6 integer run", cnt, 1);
    do_write(1'b1, 3'd0, 20'h10000);
    chk("R6 integer overflow flag", int'(cfg_err_o), 1);
    run_count(7'b0000001, 600, cnt);
    chk("R6 phase kept across refused write", cnt, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule